// File: doc/BRIEF.md
# Condition Flag and Next-PC Unit

This block is the control-flow slice of a 16-bit load/store core. It keeps the three condition flags (negative, zero, positive). It refreshes them from every value the datapath writes into the register file. From the instruction currently being executed it works out whether the program counter must be reloaded, and with which value.

The unit covers the conditional branch, the direct jump and call, the register-based jump and call, the return, and the system trap. For a call or a trap it asks the datapath to write the link value into R7. For a trap it presents the vector-table address and takes the table word back as the new PC. Direct targets keep the upper bits of the PC and replace only its low page field. Fetch, the register file and the ALU sit outside the block. The datapath supplies the incremented PC, the base register value, R7 and the trap-table read data, all combinationally.

Top module: `flow_ctrl_unit`

## Requirements
- R1: While reset is asserted, the flags `cc_flags` ({N,Z,P}) become 3'b010, meaning Z=1, N=0 and P=0.
- R2: A register write (`reg_we`=1) that is not a link write updates the flags at the next clock edge. N=1 if bit 15 of the data is 1, otherwise Z=1 if the data is zero, otherwise P=1. Exactly one flag is ever set.
- R3: The flags hold their value when `reg_we`=0. They also hold when `reg_we`=1 in a cycle where `link_we`=1, so a link write to R7 leaves them unchanged.
- R4: A branch (opcode bits [15:12]=4'b0000) takes its mask n,z,p from bits [11:9]. It is taken exactly when (N&n)|(Z&z)|(P&p), with `pc_load`=1 only when it is taken. A mask of 000 is never taken and a mask of 111 is always taken.
- R5: The target of a taken branch, and of a direct jump, is {pc_inc[15:9], instr[8:0]}.
- R6: A direct jump (opcode 4'b0100) always sets `pc_load`=1. It sets `link_we` equal to instruction bit 11.
- R7: A register jump (opcode 4'b1100) sets `pc_load`=1 and `next_pc` = `base_val` + zero-extended instr[5:0], modulo 2^16. It sets `link_we` equal to bit 11.
- R8: A return (opcode 4'b1101) sets `pc_load`=1 and `next_pc` = `r7_val`, with no link request.
- R9: A trap (opcode 4'b1111) drives `trap_addr` = {8'h00, instr[7:0]}. It sets `next_pc` = `trap_rdata`, `pc_load`=1 and `link_we`=1.
- R10: `link_data` always equals `pc_inc`, so the linked value is the already-incremented PC.
- R11: Every other opcode gives `pc_load`=0 and `link_we`=0. A link request never occurs without a PC load.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| instr | input | 16 | Instruction being executed |
| pc_inc | input | 16 | Incremented PC of that instruction |
| base_val | input | 16 | Value of the base register named by instr[8:6] |
| r7_val | input | 16 | Current value of R7 |
| trap_rdata | input | 16 | Word read from the trap table at `trap_addr` |
| reg_we | input | 1 | Register-file write strobe |
| reg_wdata | input | 16 | Data written to the register file |
| next_pc | output | 16 | PC value to load |
| pc_load | output | 1 | Load `next_pc` into the PC |
| link_we | output | 1 | Request to write `link_data` into R7 |
| link_data | output | 16 | Value to link into R7 |
| trap_addr | output | 16 | Trap-table read address |
| cc_flags | output | 3 | Condition flags {N,Z,P} |

## Verification
The bench builds the unit with its default widths: a 16-bit word, a 9-bit page field, a 6-bit base field and an 8-bit trap vector. These small fields make full sweeps affordable. The bench covers every flag state against every branch mask, all 64 base offsets (including a wrap past 16'hFFFF), all 256 trap vectors and all 16 opcodes. It also checks the case where a register write and a link request arrive together.

// File: rtl/flow_pkg.sv
package flow_pkg;
  localparam int OPC_W = 4;

  localparam logic [OPC_W-1:0] OPC_BRANCH = 4'b0000;
  localparam logic [OPC_W-1:0] OPC_JDIR   = 4'b0100;
  localparam logic [OPC_W-1:0] OPC_JREG   = 4'b1100;
  localparam logic [OPC_W-1:0] OPC_RETURN = 4'b1101;
  localparam logic [OPC_W-1:0] OPC_TRAP   = 4'b1111;

  typedef struct packed {
    logic neg;
    logic zero;
    logic pos;
  } cc_t;

  localparam cc_t CC_RESET = '{neg: 1'b0, zero: 1'b1, pos: 1'b0};
endpackage

// File: rtl/cc_flag_reg.sv
module cc_flag_reg
  import flow_pkg::*;
#(
  parameter int DATA_W = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [DATA_W-1:0] wr_data,
  output cc_t               flags
);

  function automatic cc_t classify(input logic [DATA_W-1:0] v);
    cc_t c;
    c.neg  = v[DATA_W-1];
    c.zero = (v == '0);
    c.pos  = !v[DATA_W-1] && (v != '0);
    return c;
  endfunction

  cc_t next_flags;
  assign next_flags = classify(wr_data);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)     flags <= CC_RESET;
    else if (wr_en) flags <= next_flags;
  end

  assert_reset_value_R1: assert property (@(posedge clk)
    !rst_n |=> (flags == CC_RESET));

  assert_one_flag_R2: assert property (@(posedge clk) disable iff (!rst_n)
    $countones(flags) == 1);

  assert_sign_follows_R2: assert property (@(posedge clk) disable iff (!rst_n)
    wr_en |=> (flags.neg == $past(wr_data[DATA_W-1])));

  assert_hold_when_idle_R3: assert property (@(posedge clk) disable iff (!rst_n)
    !wr_en |=> $stable(flags));

endmodule

// File: rtl/branch_cond.sv
module branch_cond
  import flow_pkg::*;
(
  input  cc_t        flags,
  input  logic [2:0] mask,
  output logic       taken
);

  function automatic logic test_mask(input cc_t f, input logic [2:0] m);
    return (f.neg & m[2]) | (f.zero & m[1]) | (f.pos & m[0]);
  endfunction

  assign taken = test_mask(flags, mask);

endmodule

// File: rtl/target_sel.sv
module target_sel
  import flow_pkg::*;
#(
  parameter int DATA_W = 16,
  parameter int PAGE_W = 9,
  parameter int BASE_W = 6,
  parameter int VEC_W  = 8
) (
  input  logic [OPC_W-1:0]  opcode,
  input  logic              link_bit,
  input  logic [PAGE_W-1:0] low_field,
  input  logic              br_taken,
  input  logic [DATA_W-1:0] pc_inc,
  input  logic [DATA_W-1:0] base_val,
  input  logic [DATA_W-1:0] r7_val,
  input  logic [DATA_W-1:0] trap_rdata,
  output logic [DATA_W-1:0] next_pc,
  output logic              pc_load,
  output logic              link_we,
  output logic [DATA_W-1:0] trap_addr
);

  function automatic logic [DATA_W-1:0] page_target(
      input logic [DATA_W-1:0] pc, input logic [PAGE_W-1:0] off);
    return {pc[DATA_W-1:PAGE_W], off};
  endfunction

  function automatic logic [DATA_W-1:0] reg_target(
      input logic [DATA_W-1:0] base, input logic [BASE_W-1:0] off);
    return base + DATA_W'(off);
  endfunction

  assign trap_addr = DATA_W'(low_field[VEC_W-1:0]);

  always_comb begin
    next_pc = pc_inc;
    pc_load = 1'b0;
    link_we = 1'b0;
    case (opcode)
      OPC_BRANCH: begin
        next_pc = page_target(pc_inc, low_field);
        pc_load = br_taken;
      end
      OPC_JDIR: begin
        next_pc = page_target(pc_inc, low_field);
        pc_load = 1'b1;
        link_we = link_bit;
      end
      OPC_JREG: begin
        next_pc = reg_target(base_val, low_field[BASE_W-1:0]);
        pc_load = 1'b1;
        link_we = link_bit;
      end
      OPC_RETURN: begin
        next_pc = r7_val;
        pc_load = 1'b1;
      end
      OPC_TRAP: begin
        next_pc = trap_rdata;
        pc_load = 1'b1;
        link_we = 1'b1;
      end
      default: ;
    endcase
  end

endmodule

// File: rtl/flow_ctrl_unit.sv
module flow_ctrl_unit
  import flow_pkg::*;
#(
  parameter int DATA_W = 16,
  parameter int PAGE_W = 9,
  parameter int BASE_W = 6,
  parameter int VEC_W  = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [DATA_W-1:0] instr,
  input  logic [DATA_W-1:0] pc_inc,
  input  logic [DATA_W-1:0] base_val,
  input  logic [DATA_W-1:0] r7_val,
  input  logic [DATA_W-1:0] trap_rdata,
  input  logic              reg_we,
  input  logic [DATA_W-1:0] reg_wdata,
  output logic [DATA_W-1:0] next_pc,
  output logic              pc_load,
  output logic              link_we,
  output logic [DATA_W-1:0] link_data,
  output logic [DATA_W-1:0] trap_addr,
  output logic [2:0]        cc_flags
);

  localparam int OPC_LSB  = DATA_W - OPC_W;
  localparam int LINK_POS = OPC_LSB - 1;
  localparam int MASK_LSB = OPC_LSB - 3;

  logic [OPC_W-1:0] opcode;
  logic [2:0]       br_mask;
  logic             link_bit;
  logic             br_taken;
  logic             flag_wr_en;
  cc_t              flags;

  assign opcode   = instr[DATA_W-1:OPC_LSB];
  assign br_mask  = instr[OPC_LSB-1:MASK_LSB];
  assign link_bit = instr[LINK_POS];

  // A link write into R7 is not a flag-setting write.
  assign flag_wr_en = reg_we && !link_we;

  cc_flag_reg #(.DATA_W(DATA_W)) u_flags (
    .clk     (clk),
    .rst_n   (rst_n),
    .wr_en   (flag_wr_en),
    .wr_data (reg_wdata),
    .flags   (flags)
  );

  branch_cond u_cond (
    .flags (flags),
    .mask  (br_mask),
    .taken (br_taken)
  );

  target_sel #(
    .DATA_W (DATA_W),
    .PAGE_W (PAGE_W),
    .BASE_W (BASE_W),
    .VEC_W  (VEC_W)
  ) u_target (
    .opcode     (opcode),
    .link_bit   (link_bit),
    .low_field  (instr[PAGE_W-1:0]),
    .br_taken   (br_taken),
    .pc_inc     (pc_inc),
    .base_val   (base_val),
    .r7_val     (r7_val),
    .trap_rdata (trap_rdata),
    .next_pc    (next_pc),
    .pc_load    (pc_load),
    .link_we    (link_we),
    .trap_addr  (trap_addr)
  );

  assign link_data = pc_inc;
  assign cc_flags  = flags;

  assert_link_hold_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_we && link_we) |=> $stable(flags));

  assert_empty_mask_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (opcode == OPC_BRANCH && br_mask == 3'b000) |-> !pc_load);

  assert_full_mask_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (opcode == OPC_BRANCH && br_mask == 3'b111) |-> pc_load);

  assert_trap_link_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (opcode == OPC_TRAP) |-> (pc_load && link_we && trap_addr[DATA_W-1:VEC_W] == '0));

  assert_link_needs_load_R11: assert property (@(posedge clk) disable iff (!rst_n)
    link_we |-> pc_load);

endmodule

// File: tb/flow_ctrl_unit_bench.sv
`timescale 1ns/1ps
module flow_ctrl_unit_bench;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [15:0] instr = '0, pc_inc = '0, base_val = '0, r7_val = '0, trap_rdata = '0;
  logic        reg_we = 1'b0;
  logic [15:0] reg_wdata = '0;
  logic [15:0] next_pc, link_data, trap_addr;
  logic        pc_load, link_we;
  logic [2:0]  cc_flags;

  int total = 0;
  int bad = 0;
  bit done = 0;

  always #5 clk = ~clk;

  flow_ctrl_unit u_flow_ctrl_unit (
    .clk(clk), .rst_n(rst_n), .instr(instr), .pc_inc(pc_inc),
    .base_val(base_val), .r7_val(r7_val), .trap_rdata(trap_rdata),
    .reg_we(reg_we), .reg_wdata(reg_wdata), .next_pc(next_pc),
    .pc_load(pc_load), .link_we(link_we), .link_data(link_data),
    .trap_addr(trap_addr), .cc_flags(cc_flags)
  );

  task automatic chk(input string tag, input logic [15:0] act, input logic [15:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  function automatic logic [2:0] flags_for(input logic [15:0] v);
    if (v[15]) return 3'b100;
    if (v == 16'h0000) return 3'b010;
    return 3'b001;
  endfunction

  task automatic write_reg(input logic [15:0] v);
    @(negedge clk);
    instr = 16'h2000; reg_we = 1'b1; reg_wdata = v;
    @(posedge clk);
    @(negedge clk);
    reg_we = 1'b0;
  endtask

  task automatic apply(input logic [15:0] ins);
    @(negedge clk);
    instr = ins;
    #1;
  endtask

  initial begin
    logic [15:0] vals [6];
    logic [15:0] flag_src [3];
    vals = '{16'h0000, 16'h0001, 16'h7FFF, 16'h8000, 16'hFFFF, 16'h1234};
    flag_src = '{16'hC001, 16'h0000, 16'h0042};

    repeat (3) @(posedge clk);
    @(negedge clk);
    chk("R1 reset flags", {13'b0, cc_flags}, 16'h0002);
    rst_n = 1'b1;

    // R2: flag classification sweep
    foreach (vals[i]) begin
      write_reg(vals[i]);
      chk("R2 flags after write", {13'b0, cc_flags}, {13'b0, flags_for(vals[i])});
    end

    // R3: idle cycles leave the flags alone
    write_reg(16'h8001);
    @(negedge clk); reg_wdata = 16'h0000; instr = 16'h1234;
    repeat (3) @(negedge clk);
    chk("R3 hold while idle", {13'b0, cc_flags}, 16'h0004);

    // R3: register write in a link cycle is ignored
    write_reg(16'h0005);
    @(negedge clk);
    instr = 16'h4800; pc_inc = 16'h3000; reg_we = 1'b1; reg_wdata = 16'h8000;
    #1 chk("R6 link request on call", {15'b0, link_we}, 16'h0001);
    @(posedge clk); @(negedge clk);
    reg_we = 1'b0;
    chk("R3 link write keeps flags", {13'b0, cc_flags}, 16'h0001);

    // R4/R5: every flag state against every mask
    pc_inc = 16'hB3C4;
    foreach (flag_src[f]) begin
      write_reg(flag_src[f]);
      for (int m = 0; m < 8; m++) begin
        logic tk;
        tk = |(3'(m) & flags_for(flag_src[f]));
        apply({4'b0000, 3'(m), 9'h0A5});
        chk("R4 branch decision", {15'b0, pc_load}, {15'b0, tk});
        chk("R11 branch never links", {15'b0, link_we}, 16'h0000);
        if (tk) chk("R5 branch target", next_pc, {pc_inc[15:9], 9'h0A5});
      end
    end

    // R6/R5/R10: direct jumps with and without link
    for (int k = 0; k < 4; k++) begin
      logic l;
      l = k[0];
      pc_inc = 16'h1F00 + 16'(k * 16'h2345);
      apply({4'b0100, l, 2'b00, 9'(k * 77 + 3)});
      chk("R6 jump load", {15'b0, pc_load}, 16'h0001);
      chk("R6 jump link", {15'b0, link_we}, {15'b0, l});
      chk("R5 jump target", next_pc, {pc_inc[15:9], 9'(k * 77 + 3)});
      chk("R10 link value", link_data, pc_inc);
    end

    // R7: every base offset, two base values, one wrapping
    for (int b = 0; b < 64; b++) begin
      base_val = b[1] ? 16'hFFE7 : 16'h1200;
      apply({4'b1100, b[0], 2'b00, 3'b101, 6'(b)});
      chk("R7 register jump target", next_pc, base_val + 16'(b));
      chk("R7 register jump link", {15'b0, link_we}, {15'b0, b[0]});
      chk("R7 register jump load", {15'b0, pc_load}, 16'h0001);
    end

    // R8: return
    for (int k = 0; k < 3; k++) begin
      r7_val = 16'hA5A5 ^ 16'(k * 16'h1111);
      apply(16'hD000);
      chk("R8 return target", next_pc, r7_val);
      chk("R8 return load", {15'b0, pc_load}, 16'h0001);
      chk("R8 return no link", {15'b0, link_we}, 16'h0000);
    end

    // R9: all trap vectors
    for (int v = 0; v < 256; v++) begin
      @(negedge clk);
      instr = {8'hF0, 8'(v)};
      trap_rdata = (16'(v) * 16'h0101) ^ 16'h5A5A;
      #1;
      chk("R9 trap table address", trap_addr, {8'h00, 8'(v)});
      chk("R9 trap target", next_pc, (16'(v) * 16'h0101) ^ 16'h5A5A);
      chk("R9 trap link", {14'b0, link_we, pc_load}, 16'h0003);
    end

    // R11: all remaining opcodes are inert
    for (int o = 0; o < 16; o++) begin
      if (o != 0 && o != 4 && o != 12 && o != 13 && o != 15) begin
        apply({4'(o), 12'hFFF});
        chk("R11 inert opcode", {14'b0, pc_load, link_we}, 16'h0000);
      end
    end

    done = 1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    #2000000;
    if (!done) begin
      total++;
      bad++;
      $display("FAIL watchdog expired actual=running expected=finished");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end
endmodule